// File: doc/BRIEF.md
# Gate Shift Clock Timing Generator

This block produces two per-line timing pulses for a flat-panel driver chain: a line latch pulse for the source drivers and a shift clock pulse for the gate drivers. All line timing counts from the rising edge of the data enable input. The horizontal sync inputs play no part. Positions are counted in periods of the horizontal driver clock, which is the block's clock. The latch pulse occupies a window whose start and width are parameters.

The shift clock rises a chosen number of clock periods ahead of a reference edge of the latch pulse. A 2-bit timing select picks one of four lead times. They are spaced 17 periods apart and start at 85 periods, so at the usual clock rate they cover 2.5 µs to 4.0 µs in 0.5 µs steps. Select value 01 (3 µs) is the customary setting. A 2-bit driver-type select picks the reference edge. One driver type aligns the lead to the latch pulse's rising edge. All the others align it to the falling edge. When the lead would put the rise before the line origin, the shift clock is left out for that line.

Top module: `gate_shift_clk_gen`

## Requirements
- R1: While `rst` is high, and after it until the first rising edge of `dataEn`, both `latchPulse` and `shiftClk` are low.
- R2: A line origin is a clock edge at which `dataEn` is sampled high after being sampled low at the previous edge. A new origin restarts the position count at 0, even in the middle of a line.
- R3: If the origin is edge E0, `latchPulse` is high right after edges E(LP_START+1) through E(LP_START+LP_WIDTH). This covers positions LP_START to LP_START+LP_WIDTH-1, and the output is one register stage behind the position.
- R4: The lead time is LEAD_BASE + LEAD_STEP × `timeSel`, where `timeSel` is read as an unsigned number 0..3. The defaults are 85 and 17.
- R5: A `drvSel` of 2'b01 makes the reference position LP_START, which is the latch pulse's rising edge. Every other `drvSel` value makes it LP_START+LP_WIDTH, which is the falling edge.
- R6: `shiftClk` is high for SC_WIDTH positions. These start at the reference position minus the lead, with the same one-stage latency as R3.
- R7: If the lead is greater than the reference position, `shiftClk` stays low for the whole line. A rise position of exactly 0 is still produced.
- R8: The position count saturates at its maximum. If `dataEn` is held high, each origin yields exactly one latch pulse and one shift clock pulse.
- R9: Taking `rst` high in the middle of a pulse forces both outputs low after the next edge. After that, no pulse appears until a new origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Horizontal driver clock |
| rst | input | 1 | Synchronous reset, active high |
| dataEn | input | 1 | Data enable; its rising edge marks the line origin |
| timeSel | input | 2 | Lead time select, 0..3 |
| drvSel | input | 2 | Driver type select; 2'b01 selects the rising-edge reference |
| latchPulse | output | 1 | Source-driver line latch pulse |
| shiftClk | output | 1 | Gate-driver shift clock |

## Verification
The bench sweeps all sixteen combinations of driver type and timing select over a small configuration, checking each output position against the arithmetic expectation. This separates rising-edge from falling-edge referencing and shows each lead step. In this configuration one combination lands its rise exactly on position 0 and one needs suppression, so the sweep also separates the allowed boundary from the suppressed case. Further patterns are a truncated line followed by a fresh origin, `dataEn` held high far beyond the line length, and a reset in the middle of a pulse. These show the restart, saturation and re-arming behaviour.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  // Strobes passed from line control to the timing datapath.
  typedef struct packed {
    logic restart;     // line origin seen this cycle
    logic armed;       // at least one origin since reset
    logic useRiseRef;  // reference is the latch pulse leading edge
  } gscStrobe_t;

  localparam logic [1:0] DRV_RISE_REF = 2'b01;

endpackage

// File: rtl/gsc_line_ctrl.sv
module gsc_line_ctrl
  import gsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dataEn,
  input  logic [1:0] drvSel,
  output gscStrobe_t strobes
);

  logic prevDe;
  logic armedQ;
  logic deRise;

  assign deRise = dataEn & ~prevDe;

  // prevDe follows dataEn even in reset so a line in progress is not an origin
  always_ff @(posedge clk) begin
    prevDe <= dataEn;
    if (rst) begin
      armedQ <= 1'b0;
    end else if (deRise) begin
      armedQ <= 1'b1;
    end
  end

  always_comb begin
    strobes.restart    = deRise & ~rst;
    strobes.armed      = armedQ;
    strobes.useRiseRef = (drvSel == DRV_RISE_REF);
  end

endmodule

// File: rtl/gsc_timing_dp.sv
module gsc_timing_dp
  import gsc_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int LP_START  = 200,
  parameter int LP_WIDTH  = 24,
  parameter int SC_WIDTH  = 40,
  parameter int LEAD_BASE = 85,
  parameter int LEAD_STEP = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] timeSel,
  input  gscStrobe_t strobes,
  output logic       latchPulse,
  output logic       shiftClk
);

  localparam int NUM_LEADS = 4;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] REF_RISE = CNT_W'(LP_START);
  localparam logic [CNT_W-1:0] REF_FALL = CNT_W'(LP_START + LP_WIDTH);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] leadTab [NUM_LEADS];
  logic [CNT_W-1:0] lead;
  logic [CNT_W-1:0] refPos;
  logic [CNT_W-1:0] risePos;
  logic [CNT_W-1:0] scEnd;
  logic             riseOk;
  logic             inLp;
  logic             inSc;
  logic             lpQ;
  logic             scQ;

  // One lead value per select code
  for (genvar g = 0; g < NUM_LEADS; g++) begin : g_lead
    assign leadTab[g] = CNT_W'(LEAD_BASE + LEAD_STEP * g);
  end

  // Position counter: cleared at origin, saturates at the top
  always_ff @(posedge clk) begin
    if (rst || strobes.restart) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    lead    = leadTab[timeSel];
    refPos  = strobes.useRiseRef ? REF_RISE : REF_FALL;
    riseOk  = (refPos >= lead);
    risePos = refPos - lead;
    scEnd   = risePos + CNT_W'(SC_WIDTH);
    inLp    = (cnt >= REF_RISE) && (cnt < REF_FALL);
    inSc    = riseOk && (cnt >= risePos) && (cnt < scEnd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lpQ <= 1'b0;
      scQ <= 1'b0;
    end else begin
      lpQ <= strobes.armed && inLp;
      scQ <= strobes.armed && inSc;
    end
  end

  assign latchPulse = lpQ;
  assign shiftClk   = scQ;

endmodule

// File: rtl/gate_shift_clk_gen.sv
module gate_shift_clk_gen
  import gsc_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int LP_START  = 200,
  parameter int LP_WIDTH  = 24,
  parameter int SC_WIDTH  = 40,
  parameter int LEAD_BASE = 85,
  parameter int LEAD_STEP = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dataEn,
  input  logic [1:0] timeSel,
  input  logic [1:0] drvSel,
  output logic       latchPulse,
  output logic       shiftClk
);

  gscStrobe_t strobes;

  gsc_line_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .dataEn  (dataEn),
    .drvSel  (drvSel),
    .strobes (strobes)
  );

  gsc_timing_dp #(
    .CNT_W     (CNT_W),
    .LP_START  (LP_START),
    .LP_WIDTH  (LP_WIDTH),
    .SC_WIDTH  (SC_WIDTH),
    .LEAD_BASE (LEAD_BASE),
    .LEAD_STEP (LEAD_STEP)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .timeSel    (timeSel),
    .strobes    (strobes),
    .latchPulse (latchPulse),
    .shiftClk   (shiftClk)
  );

endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
  parameter int CNT_W    = 11,
  parameter int LP_START = 200,
  parameter int LP_WIDTH = 24,
  parameter int SC_WIDTH = 40
) (
  input logic clk,
  input logic rst,
  input logic dataEn,
  input logic latchPulse,
  input logic shiftClk
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             prevDeC;
  logic             seenRise;
  logic [CNT_W-1:0] posC;
  logic [CNT_W-1:0] lpRun;
  logic [CNT_W-1:0] scRun;

  // Port-side tracking of the line origin and output run lengths
  always_ff @(posedge clk) begin
    prevDeC <= dataEn;
    if (rst) begin
      seenRise <= 1'b0;
      posC     <= '0;
      lpRun    <= '0;
      scRun    <= '0;
    end else begin
      if (dataEn && !prevDeC) begin
        seenRise <= 1'b1;
        posC     <= '0;
      end else if (posC != CNT_MAX) begin
        posC <= posC + 1'b1;
      end
      lpRun <= latchPulse ? lpRun + 1'b1 : '0;
      scRun <= shiftClk ? scRun + 1'b1 : '0;
    end
  end

  // R1: nothing is emitted before the first origin
  a_r1_idle_before_line: assert property (@(posedge clk) disable iff (rst)
    !seenRise |-> (!latchPulse && !shiftClk));

  // R3: latch pulse starts at its configured position
  a_r3_lp_start: assert property (@(posedge clk) disable iff (rst)
    $rose(latchPulse) |-> ($past(posC) == CNT_W'(LP_START)));

  // R3: latch pulse never longer than its width
  a_r3_lp_width: assert property (@(posedge clk) disable iff (rst)
    latchPulse |-> (lpRun < CNT_W'(LP_WIDTH)));

  // R6: shift clock never longer than its width
  a_r6_sc_width: assert property (@(posedge clk) disable iff (rst)
    shiftClk |-> (scRun < CNT_W'(SC_WIDTH)));

  // R9: the cycle after reset both outputs are low
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!latchPulse && !shiftClk));

endmodule

bind gate_shift_clk_gen gsc_checker #(
  .CNT_W    (CNT_W),
  .LP_START (LP_START),
  .LP_WIDTH (LP_WIDTH),
  .SC_WIDTH (SC_WIDTH)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .dataEn     (dataEn),
  .latchPulse (latchPulse),
  .shiftClk   (shiftClk)
);

// File: tb/gate_shift_clk_gen_tb_top.sv
`timescale 1ns/1ps
module gate_shift_clk_gen_tb_top;

  localparam int CW    = 8;
  localparam int LPS   = 119;
  localparam int LPW   = 20;
  localparam int SCW   = 8;
  localparam int PMAX  = 255;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dataEn = 1'b0;
  logic [1:0] timeSel = 2'b01;
  logic [1:0] drvSel = 2'b00;
  logic       latchPulse;
  logic       shiftClk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  gate_shift_clk_gen #(
    .CNT_W(CW), .LP_START(LPS), .LP_WIDTH(LPW), .SC_WIDTH(SCW),
    .LEAD_BASE(85), .LEAD_STEP(17)
  ) dut_i (
    .clk(clk), .rst(rst), .dataEn(dataEn), .timeSel(timeSel),
    .drvSel(drvSel), .latchPulse(latchPulse), .shiftClk(shiftClk)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic bit lpExp(int p);
    return (p >= LPS) && (p < LPS + LPW);
  endfunction

  // R4 lead, R5 reference choice, R6 width, R7 suppression
  function automatic bit scExp(int p, int drv, int sel);
    int refp = (drv == 1) ? LPS : LPS + LPW;
    int lead = 85 + 17 * sel;
    if (lead > refp) return 1'b0;
    return (p >= refp - lead) && (p < refp - lead + SCW);
  endfunction

  task automatic check(bit ok, string what, int got, int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  // Origin at the first edge after this call; compares every position
  task automatic runLine(int hiLen, int total, string tag);
    int badLp = 0, badSc = 0, firstLp = -1, firstSc = -1;
    int drv = int'(drvSel);
    int sel = int'(timeSel);
    @(negedge clk);
    dataEn = 1'b1;
    for (int m = 0; m < total; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m == hiLen - 1) dataEn = 1'b0;
      if (m >= 1) begin
        int p = (m - 1 > PMAX) ? PMAX : m - 1;
        if (latchPulse !== lpExp(p)) begin
          badLp++;
          if (firstLp < 0) firstLp = p;
        end
        if (shiftClk !== scExp(p, drv, sel)) begin
          badSc++;
          if (firstSc < 0) firstSc = p;
        end
      end
    end
    check(badLp == 0, $sformatf("R3 %s latchPulse drv=%0d sel=%0d mismatches (first pos %0d)",
          tag, drv, sel, firstLp), badLp, 0);
    check(badSc == 0, $sformatf("R6 %s shiftClk drv=%0d sel=%0d mismatches (first pos %0d)",
          tag, drv, sel, firstSc), badSc, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: outputs low in reset
    check(latchPulse == 1'b0 && shiftClk == 1'b0, "R1 outputs in reset",
          {latchPulse, shiftClk}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    // R1: no origin yet, nothing emitted
    check(latchPulse == 1'b0 && shiftClk == 1'b0, "R1 outputs before first origin",
          {latchPulse, shiftClk}, 0);

    // R4 R5 R6 R7: full sweep; drv=1 sel=2 rises at 0, drv=1 sel=3 suppressed
    for (int d = 0; d < 4; d++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        drvSel  = 2'(d);
        timeSel = 2'(s);
        runLine(160, 200, "R4/R5/R7 sweep");
      end
    end

    // R2: truncated line, then a fresh origin restarts the count
    drvSel = 2'b01; timeSel = 2'b00;
    runLine(10, 40, "R2 short line");
    runLine(160, 200, "R2 after restart");

    // R8: dataEn held high well past saturation gives one pulse pair
    drvSel = 2'b10; timeSel = 2'b01;
    runLine(400, 402, "R8 held high");

    // R9: reset in the middle of the latch pulse
    @(negedge clk);
    dataEn = 1'b1;
    for (int m = 0; m < 126; m++) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(latchPulse == 1'b1, "R9 latch pulse active before reset", latchPulse, 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(latchPulse == 1'b0 && shiftClk == 1'b0, "R9 outputs after mid-pulse reset",
          {latchPulse, shiftClk}, 0);
    rst = 1'b0;
    begin
      int seen = 0;
      for (int m = 0; m < 300; m++) begin
        @(posedge clk);
        @(negedge clk);
        if (latchPulse || shiftClk) seen++;
      end
      check(seen == 0, "R9 no pulse after reset without new origin", seen, 0);
    end
    dataEn = 1'b0;
    @(negedge clk);
    runLine(160, 200, "R9 re-armed line");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule